// File: doc/BRIEF.md
# Machine-Cycle Strobe Generator with Per-Peripheral Rate Select

This block turns a free-running oscillator clock into single-cycle machine-cycle strobes: one for the processor core and one for each of seven peripherals. The peripherals are timer 0, timer 1, timer 2, the serial port (modes 0 and 2), the counter array, the watchdog and the two-wire interface. An 8-bit control register sets the rate of every strobe. Bit 0 is a global double-speed bit. When it is clear, every strobe repeats every 12 oscillator cycles. When it is set, the core strobe repeats every 6 cycles, and each peripheral's own bit picks 6 cycles (bit clear) or 12 cycles (bit set).

All strobes come from one shared modulo-6 phase counter. A toggle bit marks every second wrap of that counter. So a 12-cycle strobe always falls on the same clock as every second 6-cycle strobe. A rate change takes effect at the next wrap, and no strobe ever follows the one before it by fewer than 6 cycles.

Software reaches the register through a byte-wide write/read port at a parameterised address (default 8Fh). After reset, bit 0 is loaded from an input that carries a stored configuration default. The peripheral bits reset to zero.

Top module: `clkrate_unit`

## Requirements
- R1: While reset is asserted and at its release, the register holds 0 in bits 7..1 and the value of `x2_default` in bit 0. No strobe fires while reset is held.
- R2: A write with `bus_addr` equal to 8Fh loads the whole byte from `bus_wdata` at the next clock edge, and a read at 8Fh returns it. A write to any other address leaves the register unchanged, and a read at any other address returns 0.
- R3: With bit 0 clear, `cpu_tick` and every bit of `periph_tick` pulse once every 12 clock cycles.
- R4: With bit 0 set, `cpu_tick` pulses once every 6 clock cycles.
- R5: With bit 0 set, `periph_tick[i]` pulses every 6 cycles when register bit i+1 is 0 and every 12 cycles when it is 1. Index 0..6 maps to timer0, timer1, timer2, serial port, counter array, watchdog and two-wire interface.
- R6: With bit 0 clear, bits 7..1 have no effect on any strobe, yet they are still stored and read back as written.
- R7: Every strobe is high for exactly one clock cycle.
- R8: All strobes share one phase. A 12-cycle strobe fires only in a cycle where every 6-cycle strobe also fires.
- R9: Across any sequence of rate changes, consecutive pulses of one strobe are at least 6 clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x2_default | input | 1 | Value loaded into the global double-speed bit at reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe; the byte is written when the address matches |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register contents when the address matches, else 0 |
| cpu_tick | output | 1 | Core machine-cycle strobe |
| periph_tick | output | 7 | Peripheral strobes: timer0, timer1, timer2, serial, counter array, watchdog, two-wire |

## Verification
A table of register values drives the main function. It holds all-zero and all-peripheral-bits-set with the global bit clear, which shows that the peripheral bits are ignored. It holds the global bit alone and all bits set, which checks each channel at both rates. Alternating patterns and single-bit patterns catch a swapped or shifted channel mapping. Pulses are counted in 24-cycle windows, and a same-cycle check on the slow channels tests phase alignment. Directed tests cover reset with either default, accesses at a non-matching address, and rapid rate toggling while the minimum pulse spacing is tracked.

// File: rtl/clkrate_pkg.sv
package clkrate_pkg;

  // Shared phase: strobe fires on a base wrap, and a slow strobe only on odd wraps.
  function automatic logic tick_of(input logic base_wrap, input logic odd_wrap,
                                   input logic fast_sel);
    return base_wrap & (fast_sel | odd_wrap);
  endfunction

  // Per-channel fast selection from the control byte; channel 0 is the core.
  function automatic logic fast_of(input logic [7:0] ctl, input int unsigned ch);
    if (ch == 0) return ctl[0];
    return ctl[0] & ~ctl[ch];
  endfunction

endpackage

// File: rtl/clkrate_ctrl_reg.sv
module clkrate_ctrl_reg #(
  parameter int unsigned       DW      = 8,
  parameter logic [7:0]        REG_ADDR = 8'h8F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x2_default,
  input  logic [7:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] ctl_q
);

  logic addr_hit;
  logic wr_hit;

  assign addr_hit = (bus_addr == REG_ADDR);
  assign wr_hit   = bus_wr & addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= {{(DW-1){1'b0}}, x2_default};
    else if (wr_hit) ctl_q <= bus_wdata;
  end

  assign bus_rdata = addr_hit ? ctl_q : '0;

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ctl_q == $past(bus_wdata));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctl_q));

endmodule

// File: rtl/clkrate_phase.sv
module clkrate_phase #(
  parameter int unsigned FAST_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic base_wrap,
  output logic odd_wrap
);

  localparam int unsigned CW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(FAST_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign base_wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      odd_wrap <= 1'b0;
    end else if (base_wrap) begin
      cnt_q    <= '0;
      odd_wrap <= ~odd_wrap;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_odd_toggles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    base_wrap |=> odd_wrap != $past(odd_wrap));

  assert_odd_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !base_wrap |=> $stable(odd_wrap));

endmodule

// File: rtl/clkrate_strobe_sel.sv
module clkrate_strobe_sel #(
  parameter int unsigned FAST_DIV = 6,
  parameter int unsigned NUM_CH   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wrap,
  input  logic              odd_wrap,
  input  logic [NUM_CH-1:0] fast_sel,
  output logic [NUM_CH-1:0] tick
);
  import clkrate_pkg::*;

  localparam int unsigned SLOW_DIV = 2 * FAST_DIV;
  localparam int unsigned GW       = $clog2(SLOW_DIV + 1) + 1;
  localparam logic [GW-1:0] GMAX   = GW'(SLOW_DIV);
  localparam logic [GW-1:0] GMIN   = GW'(FAST_DIV - 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [GW-1:0] since_q;
    logic          seen_q;

    assign tick[c] = tick_of(base_wrap, odd_wrap, fast_sel[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        since_q <= '0;
        seen_q  <= 1'b0;
      end else if (tick[c]) begin
        since_q <= '0;
        seen_q  <= 1'b1;
      end else if (since_q != GMAX) begin
        since_q <= since_q + 1'b1;
      end
    end

    assert_tick_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |-> base_wrap);

    assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |=> !tick[c]);

    assert_min_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[c] && seen_q) |-> since_q >= GMIN);
  end

endmodule

// File: rtl/clkrate_unit.sv
module clkrate_unit #(
  parameter int unsigned FAST_DIV   = 6,
  parameter int unsigned NUM_PERIPH = 7,
  parameter logic [7:0]  REG_ADDR   = 8'h8F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  x2_default,
  input  logic [7:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic [NUM_PERIPH:0]   bus_wdata,
  output logic [NUM_PERIPH:0]   bus_rdata,
  output logic                  cpu_tick,
  output logic [NUM_PERIPH-1:0] periph_tick
);
  import clkrate_pkg::*;

  localparam int unsigned DW     = NUM_PERIPH + 1;
  localparam int unsigned NUM_CH = NUM_PERIPH + 1;

  logic [DW-1:0]     ctl_q;
  logic              base_wrap;
  logic              odd_wrap;
  logic [NUM_CH-1:0] fast_sel;
  logic [NUM_CH-1:0] tick;

  clkrate_ctrl_reg #(.DW(DW), .REG_ADDR(REG_ADDR)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .x2_default (x2_default),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ctl_q      (ctl_q)
  );

  clkrate_phase #(.FAST_DIV(FAST_DIV)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_wrap (base_wrap),
    .odd_wrap  (odd_wrap)
  );

  // Channel 0 is the core; channel i (1..NUM_PERIPH) follows register bit i.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign fast_sel[c] = fast_of(8'(ctl_q), c);
  end

  clkrate_strobe_sel #(.FAST_DIV(FAST_DIV), .NUM_CH(NUM_CH)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_wrap (base_wrap),
    .odd_wrap  (odd_wrap),
    .fast_sel  (fast_sel),
    .tick      (tick)
  );

  assign cpu_tick    = tick[0];
  assign periph_tick = tick[NUM_CH-1:1];

  assert_std_all_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |-> periph_tick == {NUM_PERIPH{cpu_tick}});

  assert_slow_implies_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && |periph_tick) |-> cpu_tick);

  assert_std_only_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[0] && cpu_tick) |-> odd_wrap);

endmodule

// File: tb/tb_clkrate_unit.sv
module tb_clkrate_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x2_default = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cpu_tick;
  logic [6:0] periph_tick;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  clkrate_unit dut (
    .clk(clk), .rst_n(rst_n), .x2_default(x2_default),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_tick(cpu_tick), .periph_tick(periph_tick)
  );

  // Each entry: {register value, expected fast mask (bit0 core, bit i peripheral i-1)}
  localparam logic [15:0] VEC [9] = '{
    16'h00_00, 16'hFE_00, 16'h01_FF, 16'hFF_01, 16'h55_AB,
    16'hAB_55, 16'h03_FD, 16'h81_7F, 16'h80_00
  };

  // Gap monitor for R9
  int gap [8];
  bit seen [8];
  int short_cnt = 0;
  logic [7:0] all_t;
  assign all_t = {periph_tick, cpu_tick};

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<100000", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    for (int c = 0; c < 8; c++) begin
      if (!rst_n) begin
        gap[c] = 0; seen[c] = 0;
      end else begin
        gap[c]++;
        if (all_t[c]) begin
          if (seen[c] && gap[c] < 6) short_cnt++;
          gap[c] = 0; seen[c] = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic dflt);
    @(negedge clk);
    rst_n = 1'b0; x2_default = dflt; bus_wr = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(all_t == 8'h00, "R1 no tick in reset", all_t, 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Count pulses per channel over 24 cycles; flags a slow tick without the core tick.
  task automatic window(output int cnt [8], output bit misaligned, output bit wide);
    logic [7:0] prev = 8'h00;
    misaligned = 0; wide = 0;
    for (int c = 0; c < 8; c++) cnt[c] = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      for (int c = 0; c < 8; c++) if (all_t[c]) cnt[c]++;
      if ((all_t & prev) != 0) wide = 1;
      if (|all_t && !cpu_tick && all_t[0] == 1'b0 && dut.rst_n && bus_rdata[0]) misaligned = 1;
      prev = all_t;
    end
  endtask

  initial begin
    logic [7:0] rv;
    int cnt [8];
    bit mis, wid;

    // R1: reset with default 0
    do_reset(1'b0);
    rd(8'h8F, rv);
    chk(rv == 8'h00, "R1 reset value dflt0", rv, 8'h00);
    window(cnt, mis, wid);
    chk(cnt[0] == 2, "R1 core slow after reset", cnt[0], 2);

    // R1: reset with default 1
    do_reset(1'b1);
    rd(8'h8F, rv);
    chk(rv == 8'h01, "R1 reset value dflt1", rv, 8'h01);
    window(cnt, mis, wid);
    chk(cnt[0] == 4, "R1 core fast after reset", cnt[0], 4);
    do_reset(1'b0);

    // Table walk: R3 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      logic [7:0] val, mask;
      val  = VEC[i][15:8];
      mask = VEC[i][7:0];
      wr(8'h8F, val);
      rd(8'h8F, rv);
      chk(rv == val, "R2/R6 readback", rv, val);
      window(cnt, mis, wid);
      for (int c = 0; c < 8; c++) begin
        int exp_n;
        exp_n = mask[c] ? 4 : 2;
        if (c == 0)
          chk(cnt[c] == exp_n, val[0] ? "R4 core rate" : "R3 core rate", cnt[c], exp_n);
        else if (!val[0])
          chk(cnt[c] == exp_n, "R3/R6 periph rate std", cnt[c], exp_n);
        else
          chk(cnt[c] == exp_n, "R5 periph rate x2", cnt[c], exp_n);
      end
      chk(!wid, "R7 single-cycle strobe", wid, 0);
      chk(!mis, "R8 phase alignment", mis, 0);
    end

    // R2: other address ignored
    wr(8'h8F, 8'h01);
    wr(8'h8E, 8'hFE);
    rd(8'h8F, rv);
    chk(rv == 8'h01, "R2 other-address write ignored", rv, 8'h01);
    rd(8'h90, rv);
    chk(rv == 8'h00, "R2 other-address read zero", rv, 8'h00);
    window(cnt, mis, wid);
    chk(cnt[1] == 4, "R2 ticks unchanged after stray write", cnt[1], 4);

    // R9: rapid rate toggling, core and timer0
    short_cnt = 0;
    for (int k = 0; k < 60; k++) begin
      wr(8'h8F, (k % 2) ? 8'h01 : 8'h00);
      repeat (k % 7) @(negedge clk);
    end
    for (int k = 0; k < 60; k++) begin
      wr(8'h8F, (k % 2) ? 8'h03 : 8'h01);
      repeat ((k * 3) % 5) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    chk(short_cnt == 0, "R9 min spacing under toggling", short_cnt, 0);

    summary();
  end

endmodule